// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Register

This block collects the event and error flags of an SD card host controller into one status word, gates them with an interrupt-enable word, and produces a registered interrupt request, a registered wake request and a registered error summary. Command, data and card-detect logic feed single-cycle event pulses. Buffer occupancy, buffer ready and write-CRC status are fed as live levels. Software uses a small word-addressed register port to read the status word, to clear flags by writing ones, and to read or write the enable word.

Status bit positions follow the layout that driver software decodes. Sticky bits are 31 (card inserted), 30 (card removed), 25 (buffer underrun), 24 (buffer overflow), 14 (SDIO card interrupt), 13 (command response ended), 12 (write finished), 11 (read or data transfer finished), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) and 0 (read timeout). Live bits are 29/28 (buffer halves empty), 27/26 (buffer halves full), 10:9 (write-CRC status code, where 2 means no CRC reply), 7 (read data ready) and 6 (write space ready).

Top module: `sdh_irq_top`

## Requirements
- R1: After reset the sticky flags are 0, the enable word reads 0, and irqReq, wakeReq and errAny are 0.
- R2: An evtIn pulse on a sticky bit position sets that status bit after the next clock edge, and the bit stays set while no clear is written to it.
- R3: A write to word 0 clears each sticky bit whose write-data bit is 1 and leaves the bits written as 0. If an event and a clear hit the same bit in the same cycle, the bit ends set.
- R4: evtIn bits at non-sticky positions have no effect on the status word.
- R5: Live bits mirror their inputs in the same cycle: bufEmpty at 29:28, bufFull at 27:26, wrCrcCode at 10:9, rdReady at 7 and wrReady at 6. Clear writes have no effect on them.
- R6: Word 1 is the enable word. Only bits 18..12 and 4..0 are stored (mask 0x0007F01F), and the other bits read 0.
- R7: irqReq is registered. It is the OR of the following pairs (enable bit, source): 15 with status bit 31, 14 with bit 30, 13 with bit 14, 12 with dat0Released, 4 with bit 7, 3 with bit 6, 2 with bit 13, 1 with bit 12, and 0 with bit 11.
- R8: irqReq drops one edge after the status bit that drives it is cleared or goes low, or after its enable bit is cleared.
- R9: wakeReq is registered. It is the OR of enable bit 18 with status bit 14, enable bit 17 with bit 31, and enable bit 16 with bit 30.
- R10: errAny is the registered OR of the status bits under the error mask 0x2F (bits 5, 3, 2, 1, 0).
- R11: A read at any word address other than 0 or 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write when 1, read when 0 |
| busAddr | input | ADDR_W | Word address: 0 is status, 1 is enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| evtIn | input | 32 | Single-cycle event pulses at status bit positions |
| bufEmpty | input | 2 | Buffer halves empty (live) |
| bufFull | input | 2 | Buffer halves full (live) |
| rdReady | input | 1 | Read data ready in the buffer (live) |
| wrReady | input | 1 | Buffer space ready for write (live) |
| wrCrcCode | input | 2 | Write-CRC status from the card (live) |
| dat0Released | input | 1 | The card has released its busy line |
| irqReq | output | 1 | Registered interrupt request |
| wakeReq | output | 1 | Registered wake request |
| errAny | output | 1 | Registered error summary |

## Verification
An event pulse captured at edge E shows in a status read during the cycle after E. irqReq, wakeReq and errAny follow from the status and enable values present before edge E+1, so they change one edge later. Live levels show in a read in the same cycle they are applied. Before each edge the bench computes the three registered outputs from its model state and the inputs it is driving, and queues the result with the cycle number in which that result is due. The monitor samples on the falling edge and compares only the entries whose cycle has arrived, so every compare falls exactly one register stage after its cause.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int WORD_W = 32;

  // sticky flag positions: 31,30,25,24,14,13,12,11,5,3,2,1,0
  localparam logic [WORD_W-1:0] STICKY_MASK = 32'hC300_782F;
  // stored enable positions: 18..12 and 4..0
  localparam logic [WORD_W-1:0] ENABLE_MASK = 32'h0007_F01F;
  // error summary positions
  localparam logic [WORD_W-1:0] ERR_MASK    = 32'h0000_002F;

  // live level positions
  localparam int POS_EMPTY_LO = 28;
  localparam int POS_FULL_LO  = 26;
  localparam int POS_CODE_LO  = 9;
  localparam int POS_RD_RDY   = 7;
  localparam int POS_WR_RDY   = 6;

  // interrupt source map: enable bit -> status bit
  localparam int NUM_IRQ_SRC = 8;
  localparam int IRQ_EN_BIT   [NUM_IRQ_SRC] = '{15, 14, 13, 4, 3, 2, 1, 0};
  localparam int IRQ_STAT_BIT [NUM_IRQ_SRC] = '{31, 30, 14, 7, 6, 13, 12, 11};
  localparam int EN_DAT0 = 12;

  // wake source map: enable bit -> status bit
  localparam int NUM_WAKE_SRC = 3;
  localparam int WAKE_EN_BIT   [NUM_WAKE_SRC] = '{18, 17, 16};
  localparam int WAKE_STAT_BIT [NUM_WAKE_SRC] = '{14, 31, 30};

  typedef struct packed {
    logic clrStatus;
    logic loadEnable;
  } regStrobe_t;
endpackage

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
  import sdh_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_IDX = 0,
  parameter int ENABLE_IDX = 1
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] statusWord,
  input  logic [WORD_W-1:0] enableWord,
  output regStrobe_t        strobe,
  output logic [WORD_W-1:0] busRdata
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_IDX);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(ENABLE_IDX);

  logic hitStat;
  logic hitEn;

  assign hitStat = (busAddr == STAT_A);
  assign hitEn   = (busAddr == EN_A);

  always_comb begin
    strobe.clrStatus  = busSel & busWrite & hitStat;
    strobe.loadEnable = busSel & busWrite & hitEn;
  end

  always_comb begin
    if (hitStat)    busRdata = statusWord;
    else if (hitEn) busRdata = enableWord;
    else            busRdata = '0;
  end
endmodule

// File: rtl/sdh_irq_dp.sv
module sdh_irq_dp
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] evtIn,
  input  logic [1:0]        bufEmpty,
  input  logic [1:0]        bufFull,
  input  logic              rdReady,
  input  logic              wrReady,
  input  logic [1:0]        wrCrcCode,
  input  logic              dat0Released,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] enableWord,
  output logic              irqReq,
  output logic              wakeReq,
  output logic              errAny
);
  logic [WORD_W-1:0]       stickyQ;
  logic [WORD_W-1:0]       enableQ;
  logic [WORD_W-1:0]       clrMask;
  logic [WORD_W-1:0]       liveWord;
  logic [NUM_IRQ_SRC-1:0]  irqHit;
  logic [NUM_WAKE_SRC-1:0] wakeHit;
  logic                    dat0Hit;

  assign clrMask = strobe.clrStatus ? wrData : '0;

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= ((stickyQ & ~clrMask) | evtIn) & STICKY_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  enableQ <= '0;
    else if (strobe.loadEnable) enableQ <= wrData & ENABLE_MASK;
  end

  always_comb begin
    liveWord = '0;
    liveWord[POS_EMPTY_LO +: 2] = bufEmpty;
    liveWord[POS_FULL_LO +: 2]  = bufFull;
    liveWord[POS_CODE_LO +: 2]  = wrCrcCode;
    liveWord[POS_RD_RDY]        = rdReady;
    liveWord[POS_WR_RDY]        = wrReady;
  end

  assign statusWord = stickyQ | liveWord;
  assign enableWord = enableQ;

  for (genvar k = 0; k < NUM_IRQ_SRC; k++) begin : g_irqSrc
    assign irqHit[k] = statusWord[IRQ_STAT_BIT[k]] & enableQ[IRQ_EN_BIT[k]];
  end

  for (genvar k = 0; k < NUM_WAKE_SRC; k++) begin : g_wakeSrc
    assign wakeHit[k] = statusWord[WAKE_STAT_BIT[k]] & enableQ[WAKE_EN_BIT[k]];
  end

  assign dat0Hit = dat0Released & enableQ[EN_DAT0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq  <= 1'b0;
      wakeReq <= 1'b0;
      errAny  <= 1'b0;
    end else begin
      irqReq  <= (|irqHit) | dat0Hit;
      wakeReq <= |wakeHit;
      errAny  <= |(statusWord & ERR_MASK);
    end
  end
endmodule

// File: rtl/sdh_irq_top.sv
module sdh_irq_top
  import sdh_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_IDX = 0,
  parameter int ENABLE_IDX = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       evtIn,
  input  logic [1:0]        bufEmpty,
  input  logic [1:0]        bufFull,
  input  logic              rdReady,
  input  logic              wrReady,
  input  logic [1:0]        wrCrcCode,
  input  logic              dat0Released,
  output logic              irqReq,
  output logic              wakeReq,
  output logic              errAny
);
  regStrobe_t        strobe;
  logic [WORD_W-1:0] statusWord;
  logic [WORD_W-1:0] enableWord;

  sdh_irq_ctrl #(
    .ADDR_W    (ADDR_W),
    .STATUS_IDX(STATUS_IDX),
    .ENABLE_IDX(ENABLE_IDX)
  ) u_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .statusWord(statusWord),
    .enableWord(enableWord),
    .strobe    (strobe),
    .busRdata  (busRdata)
  );

  sdh_irq_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (busWdata),
    .evtIn       (evtIn),
    .bufEmpty    (bufEmpty),
    .bufFull     (bufFull),
    .rdReady     (rdReady),
    .wrReady     (wrReady),
    .wrCrcCode   (wrCrcCode),
    .dat0Released(dat0Released),
    .statusWord  (statusWord),
    .enableWord  (enableWord),
    .irqReq      (irqReq),
    .wakeReq     (wakeReq),
    .errAny      (errAny)
  );
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk #(
  parameter int ADDR_W     = 4,
  parameter int STATUS_IDX = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       evtIn,
  input logic [31:0]       statusWord,
  input logic [31:0]       enableWord,
  input logic              irqReq,
  input logic              wakeReq,
  input logic              errAny
);
  logic clrCmd;
  assign clrCmd = busSel && busWrite && (busAddr == ADDR_W'(STATUS_IDX)) && busWdata[13];

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableWord == 32'h0) |=> !irqReq);

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[13] && !clrCmd) |=> statusWord[13]);

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtIn[13] |=> statusWord[13]);

  // R10
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    errAny |-> $past((statusWord & 32'h2F) != 32'h0));

  // R9
  wake_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(enableWord[18:16] != 3'b000));
endmodule

bind sdh_irq_top sdh_irq_chk #(
  .ADDR_W    (ADDR_W),
  .STATUS_IDX(STATUS_IDX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .evtIn     (evtIn),
  .statusWord(statusWord),
  .enableWord(enableWord),
  .irqReq    (irqReq),
  .wakeReq   (wakeReq),
  .errAny    (errAny)
);

// File: tb/sdh_irq_top_bench.sv
`timescale 1ns/1ps
module sdh_irq_top_bench;
  localparam int ADDR_W = 4;
  localparam logic [31:0] STICKY = 32'hC300_782F;
  localparam logic [31:0] ENMASK = 32'h0007_F01F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              busSel = 0, busWrite = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0, busRdata, evtIn = '0;
  logic [1:0]        bufEmpty = '0, bufFull = '0, wrCrcCode = '0;
  logic              rdReady = 0, wrReady = 0, dat0Released = 0;
  logic              irqReq, wakeReq, errAny;

  sdh_irq_top #(.ADDR_W(ADDR_W)) u_sdh_irq_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtIn(evtIn), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .rdReady(rdReady), .wrReady(wrReady), .wrCrcCode(wrCrcCode),
    .dat0Released(dat0Released), .irqReq(irqReq), .wakeReq(wakeReq),
    .errAny(errAny)
  );

  typedef enum int {K_RD, K_IRQ, K_WAKE, K_ERR} kind_e;
  typedef struct {
    int          due;
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  item_t       cur;
  logic [31:0] obs;
  int          cnt = 0, checks = 0, fails = 0;
  bit          done = 0;
  logic [31:0] stickyM = '0, enableM = '0;

  always @(posedge clk) cnt <= cnt + 1;

  // monitor: compares every item whose cycle has arrived
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cnt) begin
      cur = sb.pop_front();
      case (cur.kind)
        K_RD:    obs = busRdata;
        K_IRQ:   obs = {31'b0, irqReq};
        K_WAKE:  obs = {31'b0, wakeReq};
        default: obs = {31'b0, errAny};
      endcase
      checks++;
      if (obs !== cur.exp) begin
        fails++;
        $display("FAIL %s (kind %0d): actual %h expected %h", cur.tag, cur.kind, obs, cur.exp);
      end
    end
  end

  function automatic logic [31:0] liveModel();
    logic [31:0] w = '0;
    w[29:28] = bufEmpty;
    w[27:26] = bufFull;
    w[10:9]  = wrCrcCode;
    w[7]     = rdReady;
    w[6]     = wrReady;
    return w;
  endfunction

  function automatic logic irqModel(logic [31:0] s, logic [31:0] e, logic d0);
    return (s[31] & e[15]) | (s[30] & e[14]) | (s[14] & e[13]) | (d0 & e[12]) |
           (s[7] & e[4]) | (s[6] & e[3]) | (s[13] & e[2]) | (s[12] & e[1]) |
           (s[11] & e[0]);
  endfunction

  function automatic logic wakeModel(logic [31:0] s, logic [31:0] e);
    return (s[14] & e[18]) | (s[31] & e[17]) | (s[30] & e[16]);
  endfunction

  task automatic push(kind_e k, logic [31:0] v, int due, string tag);
    item_t it;
    it.due = due; it.kind = k; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // one clock edge; registered results for it are queued first
  task automatic step(string tag);
    logic [31:0] st, clr, nSticky, nEn;
    st = stickyM | liveModel();
    push(K_IRQ,  {31'b0, irqModel(st, enableM, dat0Released)}, cnt + 1, {tag, " irq R7"});
    push(K_WAKE, {31'b0, wakeModel(st, enableM)},              cnt + 1, {tag, " wake R9"});
    push(K_ERR,  {31'b0, |(st & 32'h2F)},                      cnt + 1, {tag, " err R10"});
    clr     = (busSel && busWrite && busAddr == 0) ? busWdata : '0;
    nSticky = ((stickyM & ~clr) | evtIn) & STICKY;
    nEn     = (busSel && busWrite && busAddr == 1) ? (busWdata & ENMASK) : enableM;
    @(posedge clk); #1;
    stickyM = nSticky; enableM = nEn;
    evtIn = '0; busSel = 0; busWrite = 0;
  endtask

  task automatic checkRead(int addr, string tag);
    logic [31:0] e;
    busAddr = ADDR_W'(addr);
    if (addr == 0)      e = stickyM | liveModel();
    else if (addr == 1) e = enableM;
    else                e = '0;
    push(K_RD, e, cnt, tag);
    step(tag);
  endtask

  task automatic busWr(int addr, logic [31:0] d, string tag);
    busSel = 1; busWrite = 1; busAddr = ADDR_W'(addr); busWdata = d;
    step(tag);
  endtask

  task automatic pulse(logic [31:0] v, string tag);
    evtIn = v;
    step(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    checkRead(0, "R1 status after reset");
    checkRead(1, "R1 enable after reset");

    busWr(1, 32'hFFFF_FFFF, "R6 enable write all ones");
    checkRead(1, "R6 enable readback masked");
    busWr(1, 32'h0, "R6 enable clear");

    pulse(32'h1 << 13, "R2 command-end event");
    checkRead(0, "R2 sticky set");
    step("R2 idle");
    checkRead(0, "R2 sticky held");

    busWr(1, 32'h1 << 2, "R7 enable command-end");
    step("R7 irq high");
    busWr(0, ~(32'h1 << 13), "R3 zero bits keep");
    checkRead(0, "R3 bit kept");
    busWr(0, 32'h1 << 13, "R8 clear command-end");
    step("R8 irq drops");
    checkRead(0, "R3 cleared");

    busSel = 1; busWrite = 1; busAddr = '0; busWdata = 32'h1 << 13;
    evtIn = 32'h1 << 13;
    step("R3 set wins over clear");
    checkRead(0, "R3 set wins readback");
    busWr(0, 32'hFFFF_FFFF, "R3 clear all");
    busWr(1, 32'h0, "R8 enable removed");

    pulse(~STICKY, "R4 non-sticky events");
    checkRead(0, "R4 events ignored");

    bufEmpty = 2'b10; bufFull = 2'b01; rdReady = 1; wrReady = 0; wrCrcCode = 2'd2;
    checkRead(0, "R5 live levels");
    busWr(0, 32'hFFFF_FFFF, "R5 clear on live");
    checkRead(0, "R5 live after clear");
    busWr(1, 32'h1 << 4, "R7 enable read-ready");
    step("R7 live irq");
    rdReady = 0;
    step("R8 live drop");
    wrReady = 1; bufEmpty = 2'b01; bufFull = 2'b10; wrCrcCode = 2'd1;
    busWr(1, 32'h1 << 3, "R7 enable write-ready");
    checkRead(0, "R5 live second pattern");
    wrReady = 0; bufEmpty = 0; bufFull = 0; wrCrcCode = 0;
    busWr(1, 32'h0, "R8 disable");

    busWr(1, 32'h0007_0000, "R9 wake enables");
    pulse(32'h1 << 14, "R9 card interrupt event");
    step("R9 wake high");
    busWr(0, 32'h1 << 14, "R9 clear card interrupt");
    step("R9 wake low");
    pulse(32'h1 << 31, "R9 insertion event");
    step("R9 insertion wake");
    busWr(0, 32'hFFFF_FFFF, "R9 clear all");
    busWr(1, 32'h0000_C000, "R7 insert/remove irq enables");
    pulse(32'h1 << 30, "R7 removal event");
    step("R7 removal irq");
    busWr(0, 32'hFFFF_FFFF, "R8 clear removal");
    busWr(1, 32'h0, "R8 disable all");

    pulse(32'h1 << 3, "R10 read CRC error");
    step("R10 err high");
    busWr(0, 32'h1 << 3, "R10 clear");
    step("R10 err low");
    pulse(32'h1 << 0, "R10 read timeout");
    checkRead(0, "R10 timeout flag");
    busWr(0, 32'h1, "R10 clear timeout");
    pulse(32'h1 << 25, "R10 underrun not an error");
    step("R10 err stays low");
    busWr(0, 32'hFFFF_FFFF, "R10 clear all");

    busWr(1, 32'h1 << 12, "R7 busy-release enable");
    dat0Released = 1;
    step("R7 busy-release irq");
    dat0Released = 0;
    step("R8 busy-release drop");
    busWr(1, 32'h0, "R8 disable");

    checkRead(2, "R11 unmapped read");
    checkRead(15, "R11 top address read");
    checkRead(1, "R6 final enable");

    step("flush");
    @(negedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule